// File: doc/BRIEF.md
# Reset Boot Address Selector

This block chooses the address of the first instruction fetch after a reset of a small 8-bit microcontroller. It sits between the reset controller and the program counter. It reads a nonvolatile boot status value, a stored 8-bit boot vector and a hardware strap input that requests the alternate start path. From these it forms a 16-bit start address. That address is either all zeros, or the stored vector used as the high byte with a zero low byte.

The strap input is sampled only while the power-on reset is held. The value seen on the last clock of the power-on reset is kept until the next power-on reset, and warm resets reuse it. The start address is registered on the first rising clock edge after every reset source has been released. A valid flag rises on that same edge and stays high until the next reset. A small readback group reports whether the alternate path was taken and which cause selected it: a nonzero status, the strap, or both. The core uses the valid flag to know when it may fetch from the presented address.

Top module: `boot_addr_sel`

## Requirements
- R1: When the boot status is zero and the captured strap is low, the registered start address is 16'h0000.
- R2: When the boot status is any nonzero value, the start address is the boot vector in bits 15:8 with bits 7:0 equal to zero.
- R3: If the strap input is high on the last clock edge of a power-on reset, the alternate address {vector, 8'h00} is chosen even when the status is zero.
- R4: The strap input is ignored while only the warm reset is asserted. The strap value captured at the last power-on reset keeps applying after warm resets.
- R5: While any reset is asserted, start_valid is 0 and start_addr is 0. Both are updated on the first rising clock edge after all resets are released, and start_valid then stays high until a reset.
- R6: Once start_valid is high, changes on the status, vector or strap inputs do not change any output until the next reset.
- R7: Readback: alt_by_status = (status != 0), alt_by_force = captured strap, and alt_taken = alt_by_status OR alt_by_force. All three are registered together with the address.
- R8: Unprogrammed contents (vector 8'h00, status 0) with the strap low give start address 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low |
| warm_rst_n | input | 1 | Any other reset source, active low |
| boot_status | input | STATUS_W (8) | Nonvolatile boot status value |
| boot_vector | input | VEC_W (8) | Stored high byte of the alternate start address |
| force_alt | input | 1 | Hardware strap requesting the alternate path |
| start_addr | output | ADDR_W (16) | Latched first fetch address |
| start_valid | output | 1 | Start address is ready |
| alt_taken | output | 1 | Alternate path selected |
| alt_by_status | output | 1 | Nonzero status caused the alternate path |
| alt_by_force | output | 1 | Strap caused the alternate path |

## Verification
The selector is exercised with a zero status and a nonzero status, each combined with a low and a high strap at power-on. This separates the zero path from the alternate path and attributes the alternate path to the correct cause. Warm resets with the strap toggled show that the strap is only sampled during power-on reset and that its captured value is kept. Random status, vector and strap values after the valid flag rises show that the decision is frozen. A random mix of power-on and warm resets, with status values biased towards zero, covers vectors across the full byte range.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;

  typedef struct packed {
    logic by_status;
    logic by_force;
  } alt_cause_t;

  function automatic logic alt_selected(input alt_cause_t c);
    return c.by_status | c.by_force;
  endfunction

endpackage

// File: rtl/boot_force_capture.sv
module boot_force_capture (
  input  logic clk,
  input  logic por_n,
  input  logic force_alt,
  output logic force_seen
);

  always_ff @(posedge clk) begin
    if (!por_n) force_seen <= force_alt;
  end

  // R4: outside power-on reset the captured strap never moves
  p_force_hold_r4: assert property (@(posedge clk) disable iff (!por_n)
    por_n |=> $stable(force_seen));

endmodule

// File: rtl/boot_release_ctrl.sv
module boot_release_ctrl (
  input  logic clk,
  input  logic rst_any_n,
  output logic valid_q,
  output logic latch_pulse
);

  assign latch_pulse = !valid_q;

  always_ff @(posedge clk or negedge rst_any_n) begin
    if (!rst_any_n) valid_q <= 1'b0;
    else            valid_q <= 1'b1;
  end

  p_valid_sticky_r5: assert property (@(posedge clk) disable iff (!rst_any_n)
    valid_q |=> valid_q);

  p_latch_sets_valid_r5: assert property (@(posedge clk) disable iff (!rst_any_n)
    latch_pulse |=> valid_q);

endmodule

// File: rtl/boot_addr_former.sv
module boot_addr_former
  import boot_sel_pkg::*;
#(
  parameter int STATUS_W = 8,
  parameter int VEC_W    = 8,
  parameter int ADDR_W   = 16
) (
  input  logic [STATUS_W-1:0] boot_status,
  input  logic [VEC_W-1:0]    boot_vector,
  input  logic                force_seen,
  output logic [ADDR_W-1:0]   next_addr,
  output alt_cause_t          next_cause
);

  localparam int LOW_W = ADDR_W - VEC_W;

  function automatic logic [ADDR_W-1:0] form_addr(input logic alt,
                                                  input logic [VEC_W-1:0] vec);
    return alt ? {vec, {LOW_W{1'b0}}} : '0;
  endfunction

  always_comb begin
    next_cause.by_status = |boot_status;
    next_cause.by_force  = force_seen;
    next_addr            = form_addr(alt_selected(next_cause), boot_vector);
  end

endmodule

// File: rtl/boot_addr_sel.sv
module boot_addr_sel
  import boot_sel_pkg::*;
#(
  parameter int STATUS_W = 8,
  parameter int VEC_W    = 8,
  parameter int ADDR_W   = 16
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                warm_rst_n,
  input  logic [STATUS_W-1:0] boot_status,
  input  logic [VEC_W-1:0]    boot_vector,
  input  logic                force_alt,
  output logic [ADDR_W-1:0]   start_addr,
  output logic                start_valid,
  output logic                alt_taken,
  output logic                alt_by_status,
  output logic                alt_by_force
);

  localparam int LOW_W = ADDR_W - VEC_W;

  logic             rst_any_n;
  logic             force_seen;
  logic             latch_pulse;
  logic [ADDR_W-1:0] next_addr;
  alt_cause_t       next_cause;
  alt_cause_t       cause_q;

  assign rst_any_n = por_n & warm_rst_n;

  boot_force_capture u_force (
    .clk        (clk),
    .por_n      (por_n),
    .force_alt  (force_alt),
    .force_seen (force_seen)
  );

  boot_release_ctrl u_rel (
    .clk         (clk),
    .rst_any_n   (rst_any_n),
    .valid_q     (start_valid),
    .latch_pulse (latch_pulse)
  );

  boot_addr_former #(
    .STATUS_W (STATUS_W),
    .VEC_W    (VEC_W),
    .ADDR_W   (ADDR_W)
  ) u_form (
    .boot_status (boot_status),
    .boot_vector (boot_vector),
    .force_seen  (force_seen),
    .next_addr   (next_addr),
    .next_cause  (next_cause)
  );

  always_ff @(posedge clk or negedge rst_any_n) begin
    if (!rst_any_n) begin
      start_addr <= '0;
      cause_q    <= '0;
    end else if (latch_pulse) begin
      start_addr <= next_addr;
      cause_q    <= next_cause;
    end
  end

  assign alt_by_status = cause_q.by_status;
  assign alt_by_force  = cause_q.by_force;
  assign alt_taken     = alt_selected(cause_q);

  // R1: the primary path always yields the zero address
  p_primary_zero_r1: assert property (@(posedge clk) disable iff (!rst_any_n)
    (start_valid && !alt_taken) |-> (start_addr == '0));

  // R2: the alternate path keeps the low byte clear
  p_alt_low_zero_r2: assert property (@(posedge clk) disable iff (!rst_any_n)
    alt_taken |-> (start_addr[LOW_W-1:0] == '0));

  // R6: the decision is frozen once valid
  p_addr_frozen_r6: assert property (@(posedge clk) disable iff (!rst_any_n)
    start_valid |=> ($stable(start_addr) && $stable(cause_q)));

  // R7: the latched strap cause follows the captured strap
  p_force_cause_r7: assert property (@(posedge clk) disable iff (!rst_any_n)
    latch_pulse |=> (alt_by_force == $past(force_seen)));

  // R5: nothing is reported before valid
  p_quiet_before_valid_r5: assert property (@(posedge clk) disable iff (!rst_any_n)
    !start_valid |-> (start_addr == '0 && !alt_taken));

endmodule

// File: tb/boot_addr_sel_test.sv
module boot_addr_sel_test;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        warm_rst_n = 1'b1;
  logic [7:0]  boot_status = 8'h00;
  logic [7:0]  boot_vector = 8'h00;
  logic        force_alt = 1'b0;
  logic [15:0] start_addr;
  logic        start_valid;
  logic        alt_taken;
  logic        alt_by_status;
  logic        alt_by_force;

  int total = 0;
  int bad   = 0;
  logic model_force = 1'b0;

  always #10 clk = ~clk;

  boot_addr_sel uut (
    .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n),
    .boot_status(boot_status), .boot_vector(boot_vector), .force_alt(force_alt),
    .start_addr(start_addr), .start_valid(start_valid), .alt_taken(alt_taken),
    .alt_by_status(alt_by_status), .alt_by_force(alt_by_force)
  );

  function automatic logic [15:0] exp_addr(input logic [7:0] st, input logic [7:0] vec,
                                           input logic fc);
    if (st == 8'h00 && !fc) return 16'h0000;
    return vec * 16'd256;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_outputs(input string req, input logic [7:0] st,
                               input logic [7:0] vec, input logic fc);
    check({req, " addr"},   start_addr, exp_addr(st, vec, fc));
    check({req, " valid"},  {15'd0, start_valid}, 16'd1);
    check("R7 by_status",   {15'd0, alt_by_status}, {15'd0, st != 8'h00});
    check("R7 by_force",    {15'd0, alt_by_force},  {15'd0, fc});
    check("R7 taken",       {15'd0, alt_taken},     {15'd0, (st != 8'h00) | fc});
  endtask

  // Hold reset, release it on a falling edge, check before and after the latch edge.
  task automatic do_reset(input bit power_on, input logic fc, input logic [7:0] st,
                          input logic [7:0] vec, input string req);
    @(negedge clk);
    if (power_on) por_n = 1'b0; else warm_rst_n = 1'b0;
    force_alt = fc;
    boot_status = st;
    boot_vector = vec;
    repeat (3) @(negedge clk);
    check("R5 valid low in reset", {15'd0, start_valid}, 16'd0);
    check("R5 addr zero in reset", start_addr, 16'h0000);
    if (power_on) model_force = fc;
    por_n = 1'b1;
    warm_rst_n = 1'b1;
    #1;
    check("R5 valid low before edge", {15'd0, start_valid}, 16'd0);
    @(negedge clk);
    check_outputs(req, st, vec, model_force);
  endtask

  task automatic disturb_and_check(input logic [7:0] st, input logic [7:0] vec,
                                   input logic fc);
    boot_status = 8'($urandom);
    boot_vector = 8'($urandom);
    force_alt   = 1'($urandom);
    repeat (2) @(negedge clk);
    check_outputs("R6 frozen", st, vec, fc);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20251));
    // R8: unprogrammed defaults
    do_reset(1'b1, 1'b0, 8'h00, 8'h00, "R8 defaults");
    // R1: zero status, nonzero vector, strap low
    do_reset(1'b1, 1'b0, 8'h00, 8'h5A, "R1 primary");
    // R2: nonzero status
    do_reset(1'b1, 1'b0, 8'h01, 8'hA7, "R2 status alt");
    do_reset(1'b1, 1'b0, 8'hFF, 8'hFF, "R2 status alt max");
    disturb_and_check(8'hFF, 8'hFF, 1'b0);
    // R3: strap forces the alternate path with zero status
    do_reset(1'b1, 1'b1, 8'h00, 8'h3C, "R3 strap alt");
    // R4: a warm reset keeps the captured strap even with the pin low
    do_reset(1'b0, 1'b0, 8'h00, 8'h3C, "R4 strap kept");
    // R4: strap low at power-on, then high only during a warm reset
    do_reset(1'b1, 1'b0, 8'h00, 8'h81, "R4 setup");
    do_reset(1'b0, 1'b1, 8'h00, 8'h81, "R4 strap ignored warm");
    disturb_and_check(8'h00, 8'h81, 1'b0);
    // random mix of power-on and warm resets
    for (int i = 0; i < 40; i++) begin
      logic [7:0] st;
      logic [7:0] vec;
      logic fc;
      bit pw;
      st  = ($urandom_range(0, 2) == 0) ? 8'($urandom) : 8'h00;
      vec = 8'($urandom);
      fc  = 1'($urandom);
      pw  = 1'($urandom);
      do_reset(pw, fc, st, vec, "R2/R3 random");
      disturb_and_check(st, vec, model_force);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule